// File: doc/BRIEF.md
# Byte-Register Serial Port with Receive Queue

This block is a small asynchronous serial port that a processor drives through eight byte-wide registers on word-aligned offsets. Characters always use one start bit, eight data bits sent least significant bit first, no parity and one stop bit. Software sets the line rate through a 16-bit divisor held in two bytes; the divided clock ticks four times per bit, so one bit lasts `4 * (divisor + 1)` clock cycles.

The transmitter holds exactly one character. Writing the data register while the transmitter is idle starts a frame at once, and a write while a frame is in flight is dropped. The receiver oversamples the line, samples each bit near its centre and stores good characters in a small queue that software drains by reading the data register. A single status register combines live queue and transmitter flags, two interrupt enables and two sticky error flags that software clears by writing a zero into their bit. One registered interrupt line covers both directions.

Register map (byte offsets, the index is `addr[4:2]`, accesses with `addr[1:0] != 0` are ignored and read 0): 0, 4, 8, 12 identification bytes 0..3; 16 data; 20 status/control; 24 divisor low byte; 28 divisor high byte. Status bits: 7 transmitter idle, 6 transmit interrupt enable, 5 queue empty, 4 queue one slot from full, 3 queue full, 2 receive interrupt enable, 1 overrun, 0 framing error.

Top module: `sbu_uart`

## Requirements
- R1: Reading offsets 0, 4, 8 and 12 returns bytes 0, 1, 2 and 3 of the `ID_WORD` parameter; read data appears on `rdata` one clock after the read strobe.
- R2: After reset the status register reads 8'hA0 (both enables 0, both errors 0, transmitter idle, queue empty) and both divisor bytes read 0.
- R3: The divisor bytes at offsets 24 and 28 read back as written and form `{high, low}`; every transmitted bit lasts `4 * (divisor + 1)` clocks.
- R4: A frame on `txd` is a low start bit, eight data bits LSB first and a high stop bit; `txd` is high whenever no frame is in flight.
- R5: Writing offset 16 while status bit 7 is 1 starts a frame and clears bit 7; bit 7 returns to 1 after the stop bit; a write to offset 16 while bit 7 is 0 is ignored and never transmitted.
- R6: A correctly framed character received on `rxd` enters the queue; reading offset 16 returns the oldest queued byte and removes it; status bit 5 is 1 exactly when the queue is empty.
- R7: Status bit 4 is 1 when the queue holds `FIFO_DEPTH-1` bytes and bit 3 is 1 when it holds `FIFO_DEPTH` bytes.
- R8: A character that completes while the queue is full is discarded and sets status bit 1.
- R9: A character whose stop bit samples low is discarded and sets status bit 0.
- R10: A status write sets the enables from bits 2 and 6, clears an error flag where the written bit is 0 and leaves it where it is 1; writes to bits 3, 4, 5, 7 have no effect and software cannot set an error flag.
- R11: `irq` is 1 one clock after (receive enable and (queue not empty or any error flag)) or (transmit enable and transmitter idle) holds, and 0 one clock after it does not.
- R12: Reading offset 16 with the queue empty returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Shared interrupt request, registered |

## Verification
The assertions assume the bus issues at most one strobe per cycle and that a queue read only pops when data is present, which the register decode guarantees; they also assume `rxd` frames come at the programmed rate. The stimulus writes the divisor before any traffic, keeps every received frame at exactly `4 * (divisor + 1)` clocks per bit, and leaves at least one idle bit between frames so the start detector sees a clean falling edge. Reads and writes are issued one at a time with a gap cycle, so no pop and no status write coincide with a receive completion in a way the expected values do not account for.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  // register index = byte address / 4; software depends on these positions
  typedef enum logic [2:0] {
    RG_ID0   = 3'd0,
    RG_ID1   = 3'd1,
    RG_ID2   = 3'd2,
    RG_ID3   = 3'd3,
    RG_DATA  = 3'd4,
    RG_STAT  = 3'd5,
    RG_DIVLO = 3'd6,
    RG_DIVHI = 3'd7
  } reg_sel_e;

  // status bit positions
  localparam int ST_FERR   = 0;
  localparam int ST_OERR   = 1;
  localparam int ST_RXIE   = 2;
  localparam int ST_RXFULL = 3;
  localparam int ST_RXROOM = 4;
  localparam int ST_RXEMPT = 5;
  localparam int ST_TXIE   = 6;
  localparam int ST_TXEMPT = 7;

  localparam int DIV_W    = 16;  // divisor width, two bytes
  localparam int OVS      = 4;   // ticks per bit
  localparam int OVS_W    = $clog2(OVS);
  localparam int FRAME_N  = 10;  // start + 8 data + stop
  localparam int BIT_W    = $clog2(FRAME_N);
endpackage

// File: rtl/sbu_tick.sv
module sbu_tick import sbu_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sbu_tx.sv
module sbu_tx import sbu_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  input  logic [7:0]       ldata,
  output logic             txd,
  output logic             busy
);
  logic [FRAME_N-1:0] sh;
  logic [BIT_W-1:0]   bitn;
  logic [OVS_W-1:0]   q;
  logic               tick;

  sbu_tick u_tick (.clk(clk), .rst(rst), .clr(load), .div(div), .tick(tick));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '1; busy <= 1'b0; bitn <= '0; q <= '0;
    end else if (load && !busy) begin
      sh   <= {1'b1, ldata, 1'b0};
      busy <= 1'b1;
      bitn <= '0;
      q    <= '0;
    end else if (busy && tick) begin
      q <= q + 1'b1;
      if (q == OVS_W'(OVS - 1)) begin
        sh <= {1'b1, sh[FRAME_N-1:1]};
        if (bitn == BIT_W'(FRAME_N - 1)) busy <= 1'b0;
        else                             bitn <= bitn + 1'b1;
      end
    end
  end

  assign txd = sh[0];

  assert_line_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_start_low_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/sbu_fifo.sv
module sbu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  qdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign qdata = mem[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/sbu_rx.sv
module sbu_rx import sbu_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             done,
  output logic             ferr,
  output logic [7:0]       rbyte
);
  logic             s1, rxs, active, tick;
  logic [OVS_W-1:0] q;
  logic [BIT_W-1:0] bitn;

  sbu_tick u_tick (.clk(clk), .rst(rst), .clr(!active), .div(div), .tick(tick));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; rxs <= 1'b1;
    end else begin
      s1 <= rxd; rxs <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; q <= '0; bitn <= '0; rbyte <= '0;
      done <= 1'b0; ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      ferr <= 1'b0;
      if (!active) begin
        if (!rxs) begin
          active <= 1'b1; q <= '0; bitn <= '0;
        end
      end else if (tick) begin
        q <= q + 1'b1;
        if (q == OVS_W'(OVS / 2 - 1)) begin  // bit centre
          if (bitn == '0) begin
            if (rxs) active <= 1'b0;           // glitch, not a start bit
            else     bitn <= bitn + 1'b1;
          end else if (bitn < BIT_W'(FRAME_N - 1)) begin
            rbyte <= {rxs, rbyte[7:1]};
            bitn  <= bitn + 1'b1;
          end else begin
            active <= 1'b0;
            if (rxs) done <= 1'b1;
            else     ferr <= 1'b1;
          end
        end
      end
    end
  end

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && ferr));
endmodule

// File: rtl/sbu_uart.sv
module sbu_uart import sbu_pkg::*; #(
  parameter logic [31:0] ID_WORD    = 32'h5AC3_0104,
  parameter int          FIFO_DEPTH = 4,
  parameter int          ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [7:0]       div_lo, div_hi;
  logic [DIV_W-1:0] div;
  logic             rx_ie, tx_ie, fe, oe;
  logic             tx_busy, rx_done, rx_ferr;
  logic [7:0]       rx_byte, q_data, stat;
  logic [CW-1:0]    q_cnt;
  logic             q_full, q_empty;
  logic             aligned, wr_ok, rd_ok, tx_load, q_push, q_pop, q_ovf;
  reg_sel_e         sel;

  assign div     = {div_hi, div_lo};
  assign sel     = reg_sel_e'(addr[4:2]);
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = wr_en && aligned;
  assign rd_ok   = rd_en && aligned;
  assign tx_load = wr_ok && sel == RG_DATA && !tx_busy;
  assign q_pop   = rd_ok && sel == RG_DATA && !q_empty;
  assign q_push  = rx_done && !q_full;
  assign q_ovf   = rx_done && q_full;

  sbu_tx u_tx (.clk(clk), .rst(rst), .div(div), .load(tx_load), .ldata(wdata),
               .txd(txd), .busy(tx_busy));

  sbu_rx u_rx (.clk(clk), .rst(rst), .div(div), .rxd(rxd), .done(rx_done),
               .ferr(rx_ferr), .rbyte(rx_byte));

  sbu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(q_push), .pdata(rx_byte), .pop(q_pop),
    .qdata(q_data), .count(q_cnt), .full(q_full), .empty(q_empty));

  always_comb begin
    stat            = '0;
    stat[ST_FERR]   = fe;
    stat[ST_OERR]   = oe;
    stat[ST_RXIE]   = rx_ie;
    stat[ST_RXFULL] = q_full;
    stat[ST_RXROOM] = (q_cnt == CW'(FIFO_DEPTH - 1));
    stat[ST_RXEMPT] = q_empty;
    stat[ST_TXIE]   = tx_ie;
    stat[ST_TXEMPT] = !tx_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo <= '0; div_hi <= '0; rx_ie <= 1'b0; tx_ie <= 1'b0;
      fe <= 1'b0; oe <= 1'b0;
    end else begin
      if (wr_ok && sel == RG_DIVLO) div_lo <= wdata;
      if (wr_ok && sel == RG_DIVHI) div_hi <= wdata;
      if (wr_ok && sel == RG_STAT) begin
        rx_ie <= wdata[ST_RXIE];
        tx_ie <= wdata[ST_TXIE];
        fe    <= (fe & wdata[ST_FERR]) | rx_ferr;
        oe    <= (oe & wdata[ST_OERR]) | q_ovf;
      end else begin
        fe <= fe | rx_ferr;
        oe <= oe | q_ovf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      if (aligned) begin
        unique case (sel)
          RG_ID0:   rdata <= ID_WORD[7:0];
          RG_ID1:   rdata <= ID_WORD[15:8];
          RG_ID2:   rdata <= ID_WORD[23:16];
          RG_ID3:   rdata <= ID_WORD[31:24];
          RG_DATA:  rdata <= q_empty ? 8'h00 : q_data;
          RG_STAT:  rdata <= stat;
          RG_DIVLO: rdata <= div_lo;
          RG_DIVHI: rdata <= div_hi;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (rx_ie && (!q_empty || fe || oe)) || (tx_ie && !tx_busy);
  end

  assert_ferr_hw_only_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(fe) |-> $past(rx_ferr));
  assert_oerr_hw_only_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(rx_done && q_full));
  assert_irq_rx_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_ie && !q_empty) |=> irq);
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!rx_ie && !tx_ie) |=> !irq);
  assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && sel == RG_DATA && tx_busy) |=> $stable(txd) || tx_busy);
endmodule

// File: tb/tb_sbu_uart.sv
module tb_sbu_uart;
  localparam logic [31:0] IDW  = 32'hC0DE_7A11;
  localparam int          DIVV = 3;
  localparam int          BITC = 4 * (DIVV + 1);

  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       txd, irq;

  int checks = 0, fails = 0;
  logic [7:0] txq[$];
  logic [7:0] v;

  sbu_uart #(.ID_WORD(IDW), .FIFO_DEPTH(4), .ADDR_W(5)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .irq(irq));

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  // scoreboard driver: push expectation, write the byte
  task automatic send(input logic [7:0] b);
    txq.push_back(b);
    wr(5'd16, b);
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stop_ok);
    @(negedge clk);
    rxd = 1'b0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; repeat (BITC) @(negedge clk);
    end
    rxd = stop_ok; repeat (BITC) @(negedge clk);
    rxd = 1'b1; repeat (BITC + 6) @(negedge clk);
  endtask

  task automatic wait_tx_idle();
    logic [7:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(5'd20, s);
      if (s[7]) break;
    end
  endtask

  // scoreboard monitor: decode txd and compare with the queue (R3, R4)
  initial begin
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        repeat (BITC / 2 - 1) @(negedge clk);
        chk("R4 start bit", {7'd0, txd}, 8'h00);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          got[i] = txd;
        end
        repeat (BITC) @(negedge clk);
        chk("R4 stop bit", {7'd0, txd}, 8'h01);
        if (txq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5 unexpected frame actual=%h expected=none", got);
        end else begin
          chk("R3/R4 tx byte", got, txq.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd(5'd20, v); chk("R2 status reset", v, 8'hA0);
    rd(5'd24, v); chk("R2 div lo reset", v, 8'h00);
    rd(5'd28, v); chk("R2 div hi reset", v, 8'h00);
    chk("R11 irq reset", {7'd0, irq}, 8'h00);

    rd(5'd0,  v); chk("R1 id0", v, IDW[7:0]);
    rd(5'd4,  v); chk("R1 id1", v, IDW[15:8]);
    rd(5'd8,  v); chk("R1 id2", v, IDW[23:16]);
    rd(5'd12, v); chk("R1 id3", v, IDW[31:24]);

    wr(5'd28, 8'h12); rd(5'd28, v); chk("R3 div hi readback", v, 8'h12);
    wr(5'd28, 8'h00);
    wr(5'd24, 8'(DIVV)); rd(5'd24, v); chk("R3 div lo readback", v, 8'(DIVV));

    // transmit: one-deep buffer, busy write dropped
    send(8'h55);
    rd(5'd20, v); chk("R5 tx busy clears bit7", v & 8'h80, 8'h00);
    wr(5'd16, 8'hFF);  // ignored, not pushed to scoreboard
    wait_tx_idle();
    rd(5'd20, v); chk("R5 tx idle again", v & 8'h80, 8'h80);
    send(8'hA3); wait_tx_idle();
    send(8'h00); wait_tx_idle();
    repeat (BITC) @(negedge clk);
    chk("R5 scoreboard drained", 8'(txq.size()), 8'h00);

    // receive
    rx_send(8'h3C, 1'b1);
    rd(5'd20, v); chk("R6 status not empty", v, 8'h80);
    rd(5'd16, v); chk("R6 data", v, 8'h3C);
    rd(5'd20, v); chk("R6 status empty", v, 8'hA0);
    rd(5'd16, v); chk("R12 empty read", v, 8'h00);
    rd(5'd20, v); chk("R12 no side effect", v, 8'hA0);

    // fill queue, then overrun
    rx_send(8'h01, 1'b1); rx_send(8'h82, 1'b1); rx_send(8'hC3, 1'b1);
    rd(5'd20, v); chk("R7 room for one", v, 8'h90);
    rx_send(8'h44, 1'b1);
    rd(5'd20, v); chk("R7 full", v, 8'h88);
    rx_send(8'hEE, 1'b1);
    rd(5'd20, v); chk("R8 overrun flag", v, 8'h8A);
    rd(5'd16, v); chk("R6 order 1", v, 8'h01);
    rd(5'd16, v); chk("R6 order 2", v, 8'h82);
    rd(5'd16, v); chk("R6 order 3", v, 8'hC3);
    rd(5'd16, v); chk("R8 last kept", v, 8'h44);
    rd(5'd16, v); chk("R8 overrun byte dropped", v, 8'h00);

    // status write semantics
    wr(5'd20, 8'h3A); rd(5'd20, v); chk("R10 keep flag, RO ignored", v, 8'hA2);
    wr(5'd20, 8'h00); rd(5'd20, v); chk("R10 clear flag", v, 8'hA0);
    wr(5'd20, 8'h03); rd(5'd20, v); chk("R10 no sw set", v, 8'hA0);

    // framing error
    rx_send(8'h77, 1'b0);
    rd(5'd20, v); chk("R9 frame error flag", v, 8'hA1);
    rd(5'd16, v); chk("R9 byte discarded", v, 8'h00);
    wr(5'd20, 8'h00);

    // interrupt
    wr(5'd20, 8'h04); @(negedge clk);
    chk("R11 rx en, nothing pending", {7'd0, irq}, 8'h00);
    rx_send(8'h5A, 1'b1);
    chk("R11 rx data irq", {7'd0, irq}, 8'h01);
    rd(5'd16, v); @(negedge clk);
    chk("R11 irq drops after pop", {7'd0, irq}, 8'h00);
    wr(5'd20, 8'h40); @(negedge clk);
    chk("R11 tx idle irq", {7'd0, irq}, 8'h01);
    wr(5'd20, 8'h00); @(negedge clk);
    chk("R11 irq off", {7'd0, irq}, 8'h00);
    wr(5'd20, 8'h04);
    rx_send(8'h10, 1'b0);
    chk("R11 error irq", {7'd0, irq}, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule